// File: doc/BRIEF.md
# Character Scan-Out Pixel Pipeline

This block turns a screen of 8-bit character codes held in video RAM into a serial stream of pixels, one per pixel clock. An external timing source gives it a row, a column, a line-within-row and an active flag once per character cycle, marked by a one-clock character strobe. For each character cycle the block addresses video RAM, latches the code that comes back, forms a glyph-store address from the low seven code bits and the line-within-row, loads the returned 8-bit glyph slice into a shift register and shifts it out most-significant bit first. The top code bit does not select a glyph. It inverts every pixel of that cell.

The block keeps no line buffer. Every column of every scan line is fetched again from RAM, so a processor that rewrites a cell between two scan lines changes what the very next line shows. This lets software build pixel-level pictures out of the slices of a fixed glyph set. The only per-character storage is one code latch, one address register and the shift register. Small delay registers carry the line number, the reverse bit and the active flag alongside the data.

Top module: `charpix_pipe`

## Requirements
- R1: At each clock where `char_stb` is high, `ram_addr` becomes `tm_row * 40 + tm_col` (default 40 columns, 25 rows) and holds that value until the next strobe.
- R2: At the strobe after an address is issued, the code on `ram_data` is latched. From that clock on, `rom_addr` equals `{code[6:0], line}`, with the line-within-row in bits 2:0 and the code's low seven bits in bits 9:3, and it holds until the next strobe.
- R3: At the strobe after that, the 8-bit `rom_data` slice is loaded. The 8 clocks that follow the load show its bits on `pix_out` in the order bit 7 down to bit 0, one per clock. The first pixel of a cell therefore appears two strobes after its address.
- R4: When bit 7 of a cell's code is 1, all 8 pixels of that cell are the complement of the glyph slice.
- R5: The line-within-row used in `rom_addr` is the value sampled with that same column's strobe, not the line the timing inputs show when the code is latched.
- R6: A cell sampled with `tm_active` low gives 8 pixels of 0, whatever its code or glyph.
- R7: A RAM write that lands before the strobe which latches a column's code is shown for that column on the current line. A write that lands after that strobe is shown from the next line on.
- R8: While `rst_n` is low at a clock edge, the code latch, the address and the shift register are cleared. `pix_out` is 0 after that edge, and `ram_addr` and `rom_addr` are 0 after reset.
- R9: There is no line buffer. Each scan line of a row issues its own RAM read for every column, with the same address for that column on all 8 lines of the row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| char_stb | input | 1 | One-clock strobe once per character cycle (every 8 clocks) |
| tm_active | input | 1 | Cell lies inside the visible window |
| tm_row | input | 5 | Character row of the cell |
| tm_col | input | 6 | Character column of the cell |
| tm_line | input | 3 | Line within the character row |
| ram_addr | output | 10 | Video RAM read address |
| ram_data | input | 8 | Character code read back from video RAM |
| rom_addr | output | 10 | Glyph store address: code[6:0] then line |
| rom_data | input | 8 | Glyph slice read back from the glyph store |
| pix_out | output | 1 | Serial pixel |

## Verification
A wrong address register or a wrong code latch shows at the ports within the same character cycle, as a wrong `ram_addr` or a wrong `rom_addr`. A line number that drifts out of step with its column shows as a wrong low field in `rom_addr` one strobe later. A wrong load, a wrong shift order or a wrong reverse or active flag on the shift side shows on `pix_out` within 8 clocks of the load strobe. A reference model of the whole stream is compared on every clock through a full frame. The frame includes blank intervals, reversed cells and RAM rewrites landing on both sides of a column's latching strobe.

// File: rtl/charpix_pkg.sv
// Package: default geometry and small shared helpers for the character
// scan-out pipeline. Assumes codes carry the reverse flag in their top bit.
package charpix_pkg;

    localparam int unsigned CP_COLS      = 40;  // character columns per row
    localparam int unsigned CP_ROWS      = 25;  // character rows per screen
    localparam int unsigned CP_LINES     = 8;   // scan lines per character row
    localparam int unsigned CP_PIX       = 8;   // pixels per character cycle
    localparam int unsigned CP_CODE_W    = 8;   // bits per character code

    // Linear cell index from row and column.
    function automatic int unsigned cp_cell(int unsigned row, int unsigned col,
                                            int unsigned cols);
        return row * cols + col;
    endfunction

    // Apply the reverse flag to one pixel.
    function automatic logic cp_apply_rev(logic bit_in, logic rev);
        return bit_in ^ rev;
    endfunction

endpackage

// File: rtl/cp_fetch.sv
// Fetch stage: on each character strobe, turns the sampled row/column into a
// video RAM address and carries the line number and active flag one stage on.
// Assumes row and column come from a timing source that keeps them in range.
module cp_fetch
    import charpix_pkg::*;
#(
    parameter int unsigned COLS   = CP_COLS,
    parameter int unsigned ROWS   = CP_ROWS,
    parameter int unsigned LINE_W = 3,
    parameter int unsigned ROW_W  = 5,
    parameter int unsigned COL_W  = 6,
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              active_in,
    input  logic [ROW_W-1:0]  row_in,
    input  logic [COL_W-1:0]  col_in,
    input  logic [LINE_W-1:0] line_in,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              act_out,
    output logic [LINE_W-1:0] line_out
);

    localparam int unsigned CELLS = COLS * ROWS;

    // Register the RAM address and the matching timing tag at each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_addr <= '0;
            act_out  <= 1'b0;
            line_out <= '0;
        end else if (stb) begin
            ram_addr <= ADDR_W'(cp_cell(int'(row_in), int'(col_in), COLS));
            act_out  <= active_in;
            line_out <= line_in;
        end
    end

    // R1: address only moves on a strobe.
    a_r1_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(ram_addr));

    // R1: in-range coordinates always give an in-range address.
    a_r1_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && int'(row_in) < ROWS && int'(col_in) < COLS) |=> (int'(ram_addr) < CELLS));

endmodule

// File: rtl/cp_glyph.sv
// Code stage: latches the character code returned by video RAM at the strobe
// after its address and forms the glyph store address from the low code bits
// and the line number. Assumes RAM data is valid for one full character cycle.
module cp_glyph
    import charpix_pkg::*;
#(
    parameter int unsigned CODE_W = CP_CODE_W,
    parameter int unsigned LINE_W = 3,
    parameter int unsigned ROM_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic [CODE_W-1:0] ram_data,
    input  logic              act_in,
    input  logic [LINE_W-1:0] line_in,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rev_out,
    output logic              act_out
);

    logic [CODE_W-1:0] code_q;
    logic [LINE_W-1:0] line_q;

    // Hold the single code latch and the line/active tag for this cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= '0;
            line_q  <= '0;
            act_out <= 1'b0;
        end else if (stb) begin
            code_q  <= ram_data;
            line_q  <= line_in;
            act_out <= act_in;
        end
    end

    // Glyph address: seven glyph-select bits above the line number.
    always_comb begin
        rom_addr = {code_q[CODE_W-2:0], line_q};
        rev_out  = code_q[CODE_W-1];
    end

    // R2: glyph address only moves on a strobe.
    a_r2_rom_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(rom_addr));

    // R2: glyph field tracks the RAM data seen at the strobe.
    a_r2_code_field: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> rom_addr[ROM_AW-1:LINE_W] == $past(ram_data[CODE_W-2:0]));

endmodule

// File: rtl/cp_shifter.sv
// Serialiser: loads the glyph slice at each strobe and shifts it out most
// significant bit first, applying reverse and forcing dark outside the
// active window. Assumes strobes arrive every PIX clocks.
module cp_shifter
    import charpix_pkg::*;
#(
    parameter int unsigned PIX = CP_PIX
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           stb,
    input  logic [PIX-1:0] rom_data,
    input  logic           rev_in,
    input  logic           act_in,
    output logic           pix_out
);

    logic [PIX-1:0] sh_q;
    logic           rev_q;
    logic           act_q;

    // Load a fresh slice on a strobe, otherwise shift one pixel on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            rev_q <= 1'b0;
            act_q <= 1'b0;
        end else if (stb) begin
            sh_q  <= rom_data;
            rev_q <= rev_in;
            act_q <= act_in;
        end else begin
            sh_q  <= {sh_q[PIX-2:0], 1'b0};
        end
    end

    // Output pixel with reverse and blanking applied.
    always_comb begin
        pix_out = act_q & cp_apply_rev(sh_q[PIX-1], rev_q);
    end

    // R3: a plain visible cell starts with the slice's top bit.
    a_r3_first_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && act_in && !rev_in) |=> pix_out == $past(rom_data[PIX-1]));

    // R4: a reversed visible cell starts with the inverted top bit.
    a_r4_reverse_first: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && act_in && rev_in) |=> pix_out == !$past(rom_data[PIX-1]));

    // R6: a blanked cell is dark from its first pixel.
    a_r6_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !act_in) |=> !pix_out);

    // R8: reset darkens the output.
    a_r8_reset_dark: assert property (@(posedge clk)
        !rst_n |=> !pix_out);

endmodule

// File: rtl/charpix_pipe.sv
// Top: three-stage character scan-out pipeline (address, code, serialise)
// with no line buffer. Assumes an external timing source and external RAM
// and glyph store whose read data is valid one character cycle after the
// address.
module charpix_pipe
    import charpix_pkg::*;
#(
    parameter int unsigned COLS  = CP_COLS,
    parameter int unsigned ROWS  = CP_ROWS,
    parameter int unsigned LINES = CP_LINES,
    parameter int unsigned PIX   = CP_PIX,
    parameter int unsigned CODE_W = CP_CODE_W,
    localparam int unsigned ROW_W  = $clog2(ROWS),
    localparam int unsigned COL_W  = $clog2(COLS),
    localparam int unsigned LINE_W = $clog2(LINES),
    localparam int unsigned ADDR_W = $clog2(COLS * ROWS),
    localparam int unsigned ROM_AW = CODE_W - 1 + LINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_stb,
    input  logic              tm_active,
    input  logic [ROW_W-1:0]  tm_row,
    input  logic [COL_W-1:0]  tm_col,
    input  logic [LINE_W-1:0] tm_line,
    output logic [ADDR_W-1:0] ram_addr,
    input  logic [CODE_W-1:0] ram_data,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [PIX-1:0]    rom_data,
    output logic              pix_out
);

    logic              act_s1;
    logic [LINE_W-1:0] line_s1;
    logic              act_s2;
    logic              rev_s2;

    cp_fetch #(
        .COLS(COLS), .ROWS(ROWS), .LINE_W(LINE_W),
        .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .stb(char_stb),
        .active_in(tm_active), .row_in(tm_row), .col_in(tm_col), .line_in(tm_line),
        .ram_addr(ram_addr), .act_out(act_s1), .line_out(line_s1)
    );

    cp_glyph #(
        .CODE_W(CODE_W), .LINE_W(LINE_W), .ROM_AW(ROM_AW)
    ) u_glyph (
        .clk(clk), .rst_n(rst_n), .stb(char_stb),
        .ram_data(ram_data), .act_in(act_s1), .line_in(line_s1),
        .rom_addr(rom_addr), .rev_out(rev_s2), .act_out(act_s2)
    );

    cp_shifter #(
        .PIX(PIX)
    ) u_shift (
        .clk(clk), .rst_n(rst_n), .stb(char_stb),
        .rom_data(rom_data), .rev_in(rev_s2), .act_in(act_s2),
        .pix_out(pix_out)
    );

endmodule

// File: tb/charpix_pipe_test.sv
`timescale 1ns/1ps
module charpix_pipe_test;

    localparam int COLS  = 40;
    localparam int ROWS  = 25;
    localparam int CELLS = COLS * ROWS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       char_stb = 1'b0;
    logic       tm_active = 1'b0;
    logic [4:0] tm_row = '0;
    logic [5:0] tm_col = '0;
    logic [2:0] tm_line = '0;
    logic [9:0] ram_addr;
    logic [7:0] ram_data;
    logic [9:0] rom_addr;
    logic [7:0] rom_data;
    logic       pix_out;

    logic [7:0] vram [0:CELLS-1];

    int checks = 0;
    int bad = 0;
    string cur_tag = "R3 R4 R9";

    // Model state: tuple sampled at the last strobe, byte waiting for load.
    int         p_act = 0;
    int         p_addr = 0;
    int         p_line = 0;
    logic [7:0] pend = 8'h00;
    logic [7:0] ld_byte = 8'h00;
    logic [7:0] sh_exp = 8'h00;
    int         pos = 7;
    logic [9:0] exp_rom = '0;

    always #2 clk = ~clk;

    // Glyph store content, computed.
    function automatic logic [7:0] glyph(int g, int ln);
        return 8'((g * 29 + ln * 53 + (g >> 2) * ln + 7) ^ (g << 1));
    endfunction

    assign ram_data = (int'(ram_addr) < CELLS) ? vram[ram_addr] : 8'h00;
    assign rom_data = glyph(int'(rom_addr[9:3]), int'(rom_addr[2:0]));

    charpix_pipe uut (
        .clk(clk), .rst_n(rst_n), .char_stb(char_stb), .tm_active(tm_active),
        .tm_row(tm_row), .tm_col(tm_col), .tm_line(tm_line),
        .ram_addr(ram_addr), .ram_data(ram_data),
        .rom_addr(rom_addr), .rom_data(rom_data), .pix_out(pix_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One pixel clock: drive at negedge, model, then check just after posedge.
    task automatic clk_step(input bit stb, input int act, input int row,
                            input int col, input int line);
        logic [7:0] code;
        @(negedge clk);
        char_stb  = stb;
        tm_active = act[0];
        tm_row    = 5'(row);
        tm_col    = 6'(col);
        tm_line   = 3'(line);
        if (stb) begin
            ld_byte = pend;
            code    = vram[p_addr];
            pend    = (p_act != 0) ? (glyph(int'(code[6:0]), p_line) ^ (code[7] ? 8'hFF : 8'h00)) : 8'h00;
            exp_rom = {code[6:0], 3'(p_line)};
            p_act   = act;
            p_addr  = row * COLS + col;
            p_line  = line;
        end
        @(posedge clk);
        #1;
        if (stb) begin
            sh_exp = ld_byte;
            pos    = 7;
            chk(int'(ram_addr) == p_addr, "R1 R9 ram_addr", int'(ram_addr), p_addr);
            chk(rom_addr == exp_rom, "R2 R5 rom_addr", int'(rom_addr), int'(exp_rom));
        end else if (pos > 0) begin
            pos--;
        end
        chk(pix_out == sh_exp[pos], cur_tag, int'(pix_out), int'(sh_exp[pos]));
    endtask

    task automatic char_cycle(input int act, input int row, input int col, input int line);
        clk_step(1'b1, act, row, col, line);
        for (int k = 1; k < 8; k++) clk_step(1'b0, act, row, col, line);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < CELLS; i++) vram[i] = 8'((i * 37 + 11) % 256);
        for (int c = 0; c < COLS; c++) vram[2 * COLS + c] = 8'hA0;

        // R8: reset state
        repeat (4) begin
            @(posedge clk);
            #1;
            chk(pix_out == 1'b0, "R8 pix in reset", int'(pix_out), 0);
        end
        chk(ram_addr == '0, "R8 ram_addr after reset", int'(ram_addr), 0);
        chk(rom_addr == '0, "R8 rom_addr after reset", int'(rom_addr), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int row = 0; row < ROWS; row++) begin
            for (int line = 0; line < 8; line++) begin
                cur_tag = (row == 5 && (line == 3 || line == 4)) ? "R7" : "R3 R4 R9";
                for (int col = 0; col < COLS; col++) begin
                    // R7: write before the strobe that latches column 10
                    if (row == 5 && line == 3 && col == 11) vram[5 * COLS + 10] = 8'hC5;
                    char_cycle(1, row, col, line);
                    if (row == 5 && line == 3 && col == 11)
                        chk(rom_addr[9:3] == 7'h45, "R7 early write same line", int'(rom_addr[9:3]), 'h45);
                    if (row == 5 && line == 3 && col == 22) begin
                        chk(rom_addr[9:3] == vram[5 * COLS + 21][6:0], "R7 late write not yet",
                            int'(rom_addr[9:3]), int'(vram[5 * COLS + 21][6:0]));
                        vram[5 * COLS + 21] = 8'h3B;  // R7: late write, next line
                    end
                    if (row == 5 && line == 4 && col == 22)
                        chk(rom_addr[9:3] == 7'h3B, "R7 late write next line", int'(rom_addr[9:3]), 'h3B);
                    if (row == 2 && line == 1 && col == 2)
                        chk(rom_addr[9:3] == 7'h20, "R2 reversed code field", int'(rom_addr[9:3]), 'h20);
                end
                cur_tag = "R6";
                for (int col = 0; col < 24; col++) char_cycle(0, row, 0, line);
            end
        end
        cur_tag = "R6";
        for (int k = 0; k < 4; k++) char_cycle(0, 0, 0, 0);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule